// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside the fetch stage of a program sequencer and runs counted loops without any branch instruction at the bottom of the loop body. A loop-setup command gives an iteration count and the address of the last instruction in the body. The body starts at the address right after the setup instruction. The sequencer compares every valid fetch address with the end address of the innermost active loop. When they match and iterations remain, it overrides the next program counter in that same cycle, so the jump back to the loop start costs no cycles. The redirect also consumes one iteration. When the count is used up, fetch falls through to the next address and the loop is retired.

Loops nest through a stack of loop contexts. Each context holds a start address, an end address and a remaining count. Only the innermost context is compared against the fetch address. An outer loop therefore advances only when fetch reaches its own end address. An explicit exit command abandons the innermost loop early. A setup command on a full stack raises an error pulse, and so does an exit command with no loop active.

Top module: `hwloop_seq`

## Requirements
- R1: When `fetch_valid` is high, a loop is active, `fetch_pc` equals the innermost loop's end address and that loop has more than one iteration left, `redirect` is high in the same cycle. `redirect_pc` then equals the setup instruction's address plus one.
- R2: A loop set up with count N ≥ 1 executes its body exactly N times. It redirects exactly N−1 times, then lets fetch fall through to end+1, and `depth` drops by one on the following cycle.
- R3: A count of 0 is treated as 1. Like a count of 1, the body runs once and `redirect` never rises for that loop.
- R4: With nested loops, only the innermost loop's end address is checked. An outer loop with count A that contains an inner loop with count B executes the inner body A·B times. The outer loop redirects only at its own end address.
- R5: `start_req` pushes a new innermost loop whose start address is `fetch_pc`+1. `depth` reports the number of active loops, from 0 to DEPTH (default 6), one cycle after each push or retire.
- R6: `start_req` while `depth` equals DEPTH is ignored: `depth` stays the same, and `ovf_err` is high for exactly the next cycle.
- R7: `exit_req` (without `start_req`) retires the innermost loop without a redirect. When `depth` is 0, it instead makes `unf_err` high for exactly the next cycle.
- R8: After reset, `depth` is 0, `redirect`, `ovf_err` and `unf_err` are low.
- R9: While `fetch_valid` is low, `redirect` stays low and no iteration is consumed, even when `fetch_pc` equals the end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction is fetched at `fetch_pc` this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| start_req | input | 1 | Instruction at `fetch_pc` sets up a new loop |
| start_end | input | PC_W | Address of the last instruction of the new loop body |
| start_cnt | input | CNT_W | Iteration count of the new loop (0 means 1) |
| exit_req | input | 1 | Abandon the innermost loop |
| redirect | output | 1 | Override the next program counter |
| redirect_pc | output | PC_W | Next program counter when `redirect` is high |
| depth | output | $clog2(DEPTH+1) | Number of active loops |
| ovf_err | output | 1 | Pulse: setup refused because the stack was full |
| unf_err | output | 1 | Pulse: exit requested with no loop active |

## Verification
The hardest situation to reach from the ports is a redirect at an inner end address while an outer loop is waiting underneath it, with its count untouched. The inner setup instruction must also be fetched again on every outer pass. The bench gets there by running a small fetch model: each cycle the next address is either `redirect_pc` or the address plus one. It places a setup instruction inside the body of another loop and sweeps outer count, inner count, inner body length and outer tail length. The total number of fetches must then match the closed-form product of those values.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // Action chosen for the loop stack in one cycle
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_PUSH   = 3'd1,
    ACT_REPEAT = 3'd2,
    ACT_RETIRE = 3'd3,
    ACT_EXIT   = 3'd4
  } loop_act_e;
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 6,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  loop_act_e        act,
  input  logic [PC_W-1:0]  push_start,
  input  logic [PC_W-1:0]  push_end,
  input  logic [CNT_W-1:0] push_cnt,
  output logic [SP_W-1:0]  sp,
  output logic [PC_W-1:0]  top_start,
  output logic [PC_W-1:0]  top_end,
  output logic [CNT_W-1:0] top_cnt
);

  logic [SP_W-1:0]  sp_q, sp_d;
  logic [PC_W-1:0]  start_q [DEPTH];
  logic [PC_W-1:0]  end_q   [DEPTH];
  logic [CNT_W-1:0] cnt_q   [DEPTH];

  // stack pointer next state
  always_comb begin
    sp_d = sp_q;
    case (act)
      ACT_PUSH:             sp_d = sp_q + SP_W'(1);
      ACT_RETIRE, ACT_EXIT: sp_d = sp_q - SP_W'(1);
      default:              sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  // one context register set per stack level
  for (genvar i = 0; i < DEPTH; i++) begin : g_ctx
    logic             load_en, dec_en;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      load_en = (act == ACT_PUSH)   && (sp_q == SP_W'(i));
      dec_en  = (act == ACT_REPEAT) && (sp_q == SP_W'(i + 1));
      cnt_d   = load_en ? push_cnt : (cnt_q[i] - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end else if (load_en) begin
        start_q[i] <= push_start;
        end_q[i]   <= push_end;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q[i] <= '0;
      else if (load_en || dec_en) cnt_q[i] <= cnt_d;
    end
  end

  // innermost context read-out
  always_comb begin
    top_start = '0;
    top_end   = '0;
    top_cnt   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sp_q == SP_W'(k + 1)) begin
        top_start = start_q[k];
        top_end   = end_q[k];
        top_cnt   = cnt_q[k];
      end
    end
  end

  assign sp = sp_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH)); // R5

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_PUSH |=> sp_q == $past(sp_q) + SP_W'(1)); // R5

  AST_REPEAT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_REPEAT |=> (sp_q == $past(sp_q)) && (top_cnt == $past(top_cnt) - CNT_W'(1))); // R2

endmodule

// File: rtl/hwloop_decide.sv
module hwloop_decide
  import hwloop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 6,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             start_req,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             exit_req,
  input  logic [SP_W-1:0]  sp,
  input  logic [PC_W-1:0]  top_start,
  input  logic [PC_W-1:0]  top_end,
  input  logic [CNT_W-1:0] top_cnt,
  output loop_act_e        act,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [PC_W-1:0]  push_start,
  output logic [CNT_W-1:0] push_cnt,
  output logic             ovf_hit,
  output logic             unf_hit
);

  logic empty, full, end_hit, more_left;

  always_comb begin
    empty     = (sp == '0);
    full      = (sp == SP_W'(DEPTH));
    end_hit   = fetch_valid && !empty && (fetch_pc == top_end);
    more_left = (top_cnt > CNT_W'(1));
    push_start = fetch_pc + PC_W'(1);
    push_cnt   = (start_cnt == '0) ? CNT_W'(1) : start_cnt;

    act         = ACT_NONE;
    redirect    = 1'b0;
    redirect_pc = top_start;
    ovf_hit     = 1'b0;
    unf_hit     = 1'b0;

    // setup wins over exit, exit wins over the end-address check
    if (start_req) begin
      if (full) ovf_hit = 1'b1;
      else      act     = ACT_PUSH;
    end else if (exit_req) begin
      if (empty) unf_hit = 1'b1;
      else       act     = ACT_EXIT;
    end else if (end_hit) begin
      if (more_left) begin
        act      = ACT_REPEAT;
        redirect = 1'b1;
      end else begin
        act      = ACT_RETIRE;
      end
    end
  end

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 6,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             start_req,
  input  logic [PC_W-1:0]  start_end,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             exit_req,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [SP_W-1:0]  depth,
  output logic             ovf_err,
  output logic             unf_err
);

  loop_act_e        act;
  logic [SP_W-1:0]  sp;
  logic [PC_W-1:0]  top_start, top_end, push_start;
  logic [CNT_W-1:0] top_cnt, push_cnt;
  logic             ovf_hit, unf_hit;
  logic             ovf_q, unf_q;

  hwloop_decide #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_decide (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .start_req   (start_req),
    .start_cnt   (start_cnt),
    .exit_req    (exit_req),
    .sp          (sp),
    .top_start   (top_start),
    .top_end     (top_end),
    .top_cnt     (top_cnt),
    .act         (act),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .push_start  (push_start),
    .push_cnt    (push_cnt),
    .ovf_hit     (ovf_hit),
    .unf_hit     (unf_hit)
  );

  hwloop_stack #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .push_start (push_start),
    .push_end   (start_end),
    .push_cnt   (push_cnt),
    .sp         (sp),
    .top_start  (top_start),
    .top_end    (top_end),
    .top_cnt    (top_cnt)
  );

  // error pulses, registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_hit;
      unf_q <= unf_hit;
    end
  end

  assign depth   = sp;
  assign ovf_err = ovf_q;
  assign unf_err = unf_q;

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && (depth == SP_W'(DEPTH)) |=> ovf_err && (depth == SP_W'(DEPTH))); // R6

  AST_UNF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req && exit_req && (depth == '0) |=> unf_err && (depth == '0)); // R7

  AST_REPEAT_HOLDS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> depth == $past(depth)); // R1

  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_valid && (depth != '0)); // R9

endmodule

// File: tb/tb_hwloop_seq.sv
module tb_hwloop_seq;
  localparam int PC_W  = 12;
  localparam int CNT_W = 8;
  localparam int DEPTH = 6;
  localparam int SP_W  = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             fetch_valid;
  logic [PC_W-1:0]  fetch_pc;
  logic             start_req;
  logic [PC_W-1:0]  start_end;
  logic [CNT_W-1:0] start_cnt;
  logic             exit_req;
  logic             redirect;
  logic [PC_W-1:0]  redirect_pc;
  logic [SP_W-1:0]  depth;
  logic             ovf_err, unf_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hwloop_seq #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .start_req(start_req), .start_end(start_end), .start_cnt(start_cnt),
    .exit_req(exit_req), .redirect(redirect), .redirect_pc(redirect_pc),
    .depth(depth), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, settle, caller samples after return
  task automatic drive(input bit v, input int pc, input bit st, input int se,
                       input int sc, input bit ex);
    @(negedge clk);
    fetch_valid = v;
    fetch_pc    = PC_W'(pc);
    start_req   = st;
    start_end   = PC_W'(se);
    start_cnt   = CNT_W'(sc);
    exit_req    = ex;
    #2;
  endtask

  task automatic idle();
    drive(1'b0, 0, 1'b0, 0, 0, 1'b0);
  endtask

  // fetch model: loop A at setup sa (end ea, count ca), optional loop B
  task automatic run_prog(input int p0, input int stop_pc,
                          input int sa, input int ea, input int ca,
                          input int sb, input int eb, input int cb,
                          output int fetches, output int redirs,
                          output int maxd, output int badpc);
    int pc;
    pc = p0; fetches = 0; redirs = 0; maxd = 0; badpc = 0;
    while (pc != stop_pc && fetches < 2000) begin
      if (pc == sa)      drive(1'b1, pc, 1'b1, ea, ca, 1'b0);
      else if (pc == sb) drive(1'b1, pc, 1'b1, eb, cb, 1'b0);
      else               drive(1'b1, pc, 1'b0, 0, 0, 1'b0);
      fetches++;
      if (int'(depth) > maxd) maxd = int'(depth);
      if (redirect) begin
        redirs++;
        if (pc == eb && sb >= 0) begin
          if (int'(redirect_pc) != sb + 1) badpc++;
        end else if (int'(redirect_pc) != sa + 1) badpc++;
        pc = int'(redirect_pc);
      end else pc = pc + 1;
    end
  endtask

  initial begin
    int f, r, md, bp, n1;
    fetch_valid = 0; fetch_pc = '0; start_req = 0; start_end = '0;
    start_cnt = '0; exit_req = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // R8 reset state
    check("R8 depth", int'(depth), 0);
    check("R8 redirect", int'(redirect), 0);
    check("R8 ovf_err", int'(ovf_err), 0);
    check("R8 unf_err", int'(unf_err), 0);

    // R2/R3 single loop sweep: setup at 10, body 11..10+L
    for (int n = 0; n <= 5; n++) begin
      for (int l = 1; l <= 3; l++) begin
        n1 = (n == 0) ? 1 : n;
        run_prog(10, 11 + l, 10, 10 + l, n, -1, -1, 0, f, r, md, bp);
        check($sformatf("R2 fetches n=%0d l=%0d", n, l), f, 1 + l * n1);
        check($sformatf("R3 redirects n=%0d l=%0d", n, l), r, n1 - 1);
        check("R1 redirect_pc", bp, 0);
        idle();
        check("R2 depth after retire", int'(depth), 0);
      end
    end

    // R4 nested sweep: outer setup at 40, inner setup at 41
    for (int a = 1; a <= 3; a++)
      for (int b = 1; b <= 3; b++)
        for (int li = 1; li <= 2; li++)
          for (int k = 1; k <= 2; k++) begin
            int ie, oe;
            ie = 41 + li;
            oe = ie + k;
            run_prog(40, oe + 1, 40, oe, a, 41, ie, b, f, r, md, bp);
            check($sformatf("R4 fetches a=%0d b=%0d li=%0d k=%0d", a, b, li, k),
                  f, 1 + a * (1 + li * b + k));
            check("R4 redirects", r, a * (b - 1) + (a - 1));
            check("R4 redirect_pc", bp, 0);
            check("R5 max depth", md, 2);
            idle();
            check("R4 depth after", int'(depth), 0);
          end

    // R9 and R1: loop at setup 50, end 100, count 3
    drive(1'b1, 50, 1'b1, 100, 3, 1'b0);
    drive(1'b0, 100, 1'b0, 0, 0, 1'b0);
    check("R5 depth after push", int'(depth), 1);
    check("R9 no redirect when invalid", int'(redirect), 0);
    drive(1'b0, 100, 1'b0, 0, 0, 1'b0);
    check("R9 still no redirect", int'(redirect), 0);
    drive(1'b1, 100, 1'b0, 0, 0, 1'b0);
    check("R1 redirect", int'(redirect), 1);
    check("R1 redirect_pc", int'(redirect_pc), 51);
    drive(1'b1, 100, 1'b0, 0, 0, 1'b0);
    check("R9 count untouched, second redirect", int'(redirect), 1);
    drive(1'b1, 100, 1'b0, 0, 0, 1'b0);
    check("R2 last pass falls through", int'(redirect), 0);
    idle();
    check("R2 retired", int'(depth), 0);

    // R6 overflow
    for (int i = 0; i < DEPTH; i++) drive(1'b0, 200 + i, 1'b1, 900, 5, 1'b0);
    idle();
    check("R5 full depth", int'(depth), DEPTH);
    check("R6 no ovf yet", int'(ovf_err), 0);
    drive(1'b0, 300, 1'b1, 901, 5, 1'b0);
    idle();
    check("R6 ovf pulse", int'(ovf_err), 1);
    check("R6 depth held", int'(depth), DEPTH);
    idle();
    check("R6 ovf one cycle", int'(ovf_err), 0);

    // R7 exit and underflow
    for (int i = DEPTH; i > 0; i--) begin
      drive(1'b0, 0, 1'b0, 0, 0, 1'b1);
      check("R7 no redirect on exit", int'(redirect), 0);
      idle();
      check("R7 exit pops", int'(depth), i - 1);
    end
    check("R7 no unf yet", int'(unf_err), 0);
    drive(1'b0, 0, 1'b0, 0, 0, 1'b1);
    idle();
    check("R7 unf pulse", int'(unf_err), 1);
    check("R7 depth stays 0", int'(depth), 0);
    idle();
    check("R7 unf one cycle", int'(unf_err), 0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule